// File: doc/BRIEF.md
# Two-Wire Controller Register Front-End

This block is the register file and control logic that sits between a simple word-addressed bus and the serial engine of a single-target, push-pull two-wire controller. Software programs a register index, a byte count with a direction flag, and outgoing data. It then sets a start bit. The block sends a one-cycle launch pulse to the engine, keeps the start bit reading as 1 while the engine works, and folds the engine's completion or error report into sticky status bits. Those status bits drive a level interrupt.

Status bits are cleared by writing 1 to them. A start request that arrives while a transfer is running leaves that transfer alone and raises a dedicated status flag instead. A running transfer can be cancelled with an abort bit. A soft-reset bit returns every register to its default and cancels any transfer in flight. Other registers hold the clock divider and data-output delay, manual overrides for the two bus lines with live line readback, and a stored target-initialisation word that is passed to the engine unchanged.

Register map (byte offsets, word aligned): 0x00 control, 0x04 clock configuration, 0x08 interrupt enable, 0x0C interrupt status, 0x10 and 0x14 index words 0 and 1, 0x18 length, 0x1C and 0x20 data words 0 and 1, 0x24 line control, 0x28 target-init word. Any other offset, and any address whose two low bits are not zero, reads as 0 and ignores writes.

Top module: `twc_regfront`

## Requirements
- R1: After reset, every register reads 0. The index, data and target-init words read back what was written. Unmapped or misaligned addresses read 0. Read data is 0 whenever `bus_write` is high.
- R2: Writing control with bit 7 set while idle makes `eng_start` high for exactly one cycle, on the cycle after the write. Control bit 7 then reads 1 until the transfer ends.
- R3: When `eng_done` is high during a transfer, control bit 7 reads 0 from the next cycle. If `eng_err` is 0, status bit 0 is set. If `eng_err` is 1, status bit 1 is set and status bits 15:8 take `eng_err_id`.
- R4: When a successful read transfer completes, `eng_rdata` bits 31:0 are loaded into data word 0 and bits 63:32 into data word 1, on the same clock edge that sets status bit 0. Failed transfers and write transfers leave the data words unchanged.
- R5: Writing control with bit 6 set during a transfer ends the transfer, so bit 7 reads 0. `eng_abort` pulses high for one cycle, on the cycle after the write. A later `eng_done` then has no effect. Bit 6 always reads 0.
- R6: Writing control bit 7 during a transfer (with bit 6 clear) produces no `eng_start` pulse. It sets status bit 2 instead.
- R7: Writing status with bit i set (i = 0, 1, 2) clears status bit i. Writing 0 leaves the bit as it is. When an engine event sets a bit on the same edge as a clear, the bit ends up set. Status bits 15:8 are not cleared by this write.
- R8: `irq` is high exactly when control bit 1 (global enable) is 1 and some status bit i in 0..2 is 1 whose enable bit i at offset 0x08 is also 1.
- R9: Clock configuration bits 7:0 drive `cfg_div` and bits 10:8 drive `cfg_delay`. All other bits read 0.
- R10: Line control bits 0..3 drive `sda_force_en`, `sda_force_val`, `scl_force_en` and `scl_force_val`, in that order. Bit 4 reads the live `sda_in` and bit 5 reads the live `scl_in`. Writes to bits 4 and 5 have no effect.
- R11: Writing control with bit 0 set makes bit 0 read 1 for one cycle. On the following edge every register returns to its default, and if a transfer was running, `eng_abort` pulses for one cycle.
- R12: Length bits 2:0 drive `eng_len` (byte count minus one), and length bit 4 drives `eng_read`. All other length bits read 0. The index words drive `eng_index` and the data words drive `eng_wdata`, with word 0 in the low 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq | output | 1 | Level interrupt |
| eng_start | output | 1 | One-cycle launch pulse to the engine |
| eng_abort | output | 1 | One-cycle cancel pulse to the engine |
| eng_read | output | 1 | Transfer direction, 1 = read |
| eng_len | output | 3 | Byte count minus one |
| eng_index | output | 64 | Register index words |
| eng_wdata | output | 64 | Outgoing data words |
| eng_done | input | 1 | Engine finished the current transfer |
| eng_err | input | 1 | Finished transfer failed |
| eng_err_id | input | 8 | Error identifier |
| eng_rdata | input | 64 | Returned read data |
| cfg_div | output | 8 | Clock divider |
| cfg_delay | output | 3 | Data-output delay |
| sda_force_en | output | 1 | Manual data-line control enable |
| sda_force_val | output | 1 | Manual data-line value |
| scl_force_en | output | 1 | Manual clock-line control enable |
| scl_force_val | output | 1 | Manual clock-line value |
| sda_in | input | 1 | Live data-line state |
| scl_in | input | 1 | Live clock-line state |
| init_cfg | output | 32 | Stored target-init word |

## Verification
The hardest situations to reach are same-cycle collisions. The two cases are an engine completion landing on the same edge as a status clear, and a start or abort request landing while the engine is busy. The stimulus raises `eng_done` in the same cycle as a status write. It reissues start and abort while a transfer is held open by withholding `eng_done`. It issues soft reset in the middle of a transfer, so that the one-cycle window in which the reset bit reads 1 and the following abort pulse can both be sampled.

// File: rtl/twc_pkg.sv
package twc_pkg;
  localparam int DW   = 32;
  localparam int NW   = 2;
  localparam int NREG = 11;

  // word indexes (byte offset / 4)
  localparam int W_CTRL = 0;
  localparam int W_CLK  = 1;
  localparam int W_IEN  = 2;
  localparam int W_IST  = 3;
  localparam int W_IDX0 = 4;
  localparam int W_LEN  = 6;
  localparam int W_DAT0 = 7;
  localparam int W_LINE = 9;
  localparam int W_INIT = 10;

  // control bit positions
  localparam int C_GO   = 7;
  localparam int C_STOP = 6;
  localparam int C_GIE  = 1;
  localparam int C_SRST = 0;

  localparam int LEN_RD_BIT = 4;
  localparam int EID_LSB    = 8;

  function automatic logic [DW-1:0] pack_ctrl(logic busy, logic gie, logic srst);
    logic [DW-1:0] v;
    v = '0;
    v[C_GO]   = busy;
    v[C_GIE]  = gie;
    v[C_SRST] = srst;
    return v;
  endfunction

  function automatic logic [DW-1:0] pack_line(logic [3:0] ovr, logic sda, logic scl);
    logic [DW-1:0] v;
    v = '0;
    v[3:0] = ovr;
    v[4]   = sda;
    v[5]   = scl;
    return v;
  endfunction
endpackage

// File: rtl/twc_decode.sv
module twc_decode #(
  parameter int AW   = 6,
  parameter int NREG = 11
) (
  input  logic            valid,
  input  logic [AW-1:0]   addr,
  output logic [NREG-1:0] sel
);
  localparam int IW = AW - 2;

  logic aligned;
  assign aligned = (addr[1:0] == 2'b00);

  for (genvar i = 0; i < NREG; i++) begin : g_hit
    assign sel[i] = valid && aligned && (addr[AW-1:2] == IW'(i));
  end
endmodule

// File: rtl/twc_xfer_ctrl.sv
module twc_xfer_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ctrl,
  input  logic w_go,
  input  logic w_stop,
  input  logic w_gie,
  input  logic w_srst,
  input  logic eng_done,
  input  logic eng_err,
  output logic busy,
  output logic gie,
  output logic srst,
  output logic eng_start,
  output logic eng_abort,
  output logic ev_done_ok,
  output logic ev_done_err,
  output logic ev_load_busy
);
  logic busy_q, gie_q, srst_q, start_q, abort_q;
  logic req_go, req_stop;

  assign req_go   = wr_ctrl && w_go;
  assign req_stop = wr_ctrl && w_stop;

  // named events for the status block and the assertions
  assign ev_load_busy = !srst_q && busy_q && req_go && !req_stop;
  assign ev_done_ok   = !srst_q && busy_q && !req_stop && eng_done && !eng_err;
  assign ev_done_err  = !srst_q && busy_q && !req_stop && eng_done && eng_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      gie_q   <= 1'b0;
      srst_q  <= 1'b0;
      start_q <= 1'b0;
      abort_q <= 1'b0;
    end else if (srst_q) begin
      busy_q  <= 1'b0;
      gie_q   <= 1'b0;
      srst_q  <= 1'b0;
      start_q <= 1'b0;
      abort_q <= busy_q;
    end else begin
      start_q <= 1'b0;
      abort_q <= 1'b0;
      if (wr_ctrl) begin
        gie_q  <= w_gie;
        srst_q <= w_srst;
      end
      if (busy_q) begin
        if (req_stop) begin
          busy_q  <= 1'b0;
          abort_q <= 1'b1;
        end else if (eng_done) begin
          busy_q <= 1'b0;
        end
      end else if (req_go) begin
        busy_q  <= 1'b1;
        start_q <= 1'b1;
      end
    end
  end

  assign busy      = busy_q;
  assign gie       = gie_q;
  assign srst      = srst_q;
  assign eng_start = start_q;
  assign eng_abort = abort_q;

  p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> busy);
  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eng_done && !req_stop && !srst) |=> !busy);
  p_abort_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_stop && !srst) |=> (eng_abort && !busy));
  p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load_busy |=> !eng_start);
  p_soft_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (!busy && !gie && !srst));
endmodule

// File: rtl/twc_status.sv
module twc_status #(
  parameter int EID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst,
  input  logic             gie,
  input  logic             wr_ien,
  input  logic             wr_ist,
  input  logic [2:0]       wbits,
  input  logic             ev_ok,
  input  logic             ev_err,
  input  logic             ev_lb,
  input  logic [EID_W-1:0] eid_in,
  output logic [2:0]       ien,
  output logic [2:0]       ist,
  output logic [EID_W-1:0] eid,
  output logic             irq
);
  logic [2:0]       ien_q, ist_q;
  logic [EID_W-1:0] eid_q;
  logic [2:0]       clr_mask, set_mask;

  assign clr_mask = wr_ist ? wbits : 3'b000;
  assign set_mask = {ev_lb, ev_err, ev_ok};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= '0;
      ist_q <= '0;
      eid_q <= '0;
    end else if (srst) begin
      ien_q <= '0;
      ist_q <= '0;
      eid_q <= '0;
    end else begin
      if (wr_ien) ien_q <= wbits;
      ist_q <= (ist_q & ~clr_mask) | set_mask;
      if (ev_err) eid_q <= eid_in;
    end
  end

  assign ien = ien_q;
  assign ist = ist_q;
  assign eid = eid_q;
  assign irq = gie && |(ist_q & ien_q);

  p_lb_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_lb && !srst) |=> ist[2]);
  p_w1c_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ist && wbits[0] && !ev_ok && !srst) |=> !ist[0]);
  p_err_id_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_err && !srst) |=> (ist[1] && eid == $past(eid_in)));
endmodule

// File: rtl/twc_regfront.sv
module twc_regfront #(
  parameter int AW    = 6,
  parameter int LEN_W = 3,
  parameter int EID_W = 8,
  parameter int DIV_W = 8,
  parameter int DLY_W = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            bus_valid,
  input  logic                            bus_write,
  input  logic [AW-1:0]                   bus_addr,
  input  logic [twc_pkg::DW-1:0]          bus_wdata,
  output logic [twc_pkg::DW-1:0]          bus_rdata,
  output logic                            irq,
  output logic                            eng_start,
  output logic                            eng_abort,
  output logic                            eng_read,
  output logic [LEN_W-1:0]                eng_len,
  output logic [twc_pkg::DW*twc_pkg::NW-1:0] eng_index,
  output logic [twc_pkg::DW*twc_pkg::NW-1:0] eng_wdata,
  input  logic                            eng_done,
  input  logic                            eng_err,
  input  logic [EID_W-1:0]                eng_err_id,
  input  logic [twc_pkg::DW*twc_pkg::NW-1:0] eng_rdata,
  output logic [DIV_W-1:0]                cfg_div,
  output logic [DLY_W-1:0]                cfg_delay,
  output logic                            sda_force_en,
  output logic                            sda_force_val,
  output logic                            scl_force_en,
  output logic                            scl_force_val,
  input  logic                            sda_in,
  input  logic                            scl_in,
  output logic [twc_pkg::DW-1:0]          init_cfg
);
  import twc_pkg::*;

  logic [NREG-1:0] sel, wr;
  logic busy, gie, srst;
  logic ev_ok, ev_err, ev_lb;
  logic [2:0] ien, ist;
  logic [EID_W-1:0] eid;
  logic load_rd;

  logic [DIV_W-1:0] div_q;
  logic [DLY_W-1:0] dly_q;
  logic [LEN_W-1:0] len_q;
  logic             rd_q;
  logic [3:0]       line_q;
  logic [DW-1:0]    init_q;

  twc_decode #(.AW(AW), .NREG(NREG)) u_dec (
    .valid (bus_valid),
    .addr  (bus_addr),
    .sel   (sel)
  );

  assign wr = bus_write ? sel : '0;

  twc_xfer_ctrl u_xfer (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_ctrl      (wr[W_CTRL]),
    .w_go         (bus_wdata[C_GO]),
    .w_stop       (bus_wdata[C_STOP]),
    .w_gie        (bus_wdata[C_GIE]),
    .w_srst       (bus_wdata[C_SRST]),
    .eng_done     (eng_done),
    .eng_err      (eng_err),
    .busy         (busy),
    .gie          (gie),
    .srst         (srst),
    .eng_start    (eng_start),
    .eng_abort    (eng_abort),
    .ev_done_ok   (ev_ok),
    .ev_done_err  (ev_err),
    .ev_load_busy (ev_lb)
  );

  twc_status #(.EID_W(EID_W)) u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst   (srst),
    .gie    (gie),
    .wr_ien (wr[W_IEN]),
    .wr_ist (wr[W_IST]),
    .wbits  (bus_wdata[2:0]),
    .ev_ok  (ev_ok),
    .ev_err (ev_err),
    .ev_lb  (ev_lb),
    .eid_in (eng_err_id),
    .ien    (ien),
    .ist    (ist),
    .eid    (eid),
    .irq    (irq)
  );

  // returned bytes land with the same edge that raises the complete bit
  assign load_rd = ev_ok && rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      dly_q  <= '0;
      len_q  <= '0;
      rd_q   <= 1'b0;
      line_q <= '0;
      init_q <= '0;
    end else if (srst) begin
      div_q  <= '0;
      dly_q  <= '0;
      len_q  <= '0;
      rd_q   <= 1'b0;
      line_q <= '0;
      init_q <= '0;
    end else begin
      if (wr[W_CLK]) begin
        div_q <= bus_wdata[DIV_W-1:0];
        dly_q <= bus_wdata[8 +: DLY_W];
      end
      if (wr[W_LEN]) begin
        len_q <= bus_wdata[LEN_W-1:0];
        rd_q  <= bus_wdata[LEN_RD_BIT];
      end
      if (wr[W_LINE]) line_q <= bus_wdata[3:0];
      if (wr[W_INIT]) init_q <= bus_wdata;
    end
  end

  for (genvar g = 0; g < NW; g++) begin : g_word
    logic [DW-1:0] idx_w, dat_w;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        idx_w <= '0;
        dat_w <= '0;
      end else if (srst) begin
        idx_w <= '0;
        dat_w <= '0;
      end else begin
        if (wr[W_IDX0 + g]) idx_w <= bus_wdata;
        if (load_rd) dat_w <= eng_rdata[g*DW +: DW];
        else if (wr[W_DAT0 + g]) dat_w <= bus_wdata;
      end
    end
    assign eng_index[g*DW +: DW] = idx_w;
    assign eng_wdata[g*DW +: DW] = dat_w;
  end

  // read-back views
  logic [NREG-1:0][DW-1:0] rv;
  always_comb begin
    rv = '0;
    rv[W_CTRL] = pack_ctrl(busy, gie, srst);
    rv[W_CLK][DIV_W-1:0]   = div_q;
    rv[W_CLK][8 +: DLY_W]  = dly_q;
    rv[W_IEN][2:0]         = ien;
    rv[W_IST][2:0]         = ist;
    rv[W_IST][EID_LSB +: EID_W] = eid;
    for (int k = 0; k < NW; k++) begin
      rv[W_IDX0 + k] = eng_index[k*DW +: DW];
      rv[W_DAT0 + k] = eng_wdata[k*DW +: DW];
    end
    rv[W_LEN][LEN_W-1:0]   = len_q;
    rv[W_LEN][LEN_RD_BIT]  = rd_q;
    rv[W_LINE] = pack_line(line_q, sda_in, scl_in);
    rv[W_INIT] = init_q;
  end

  always_comb begin
    bus_rdata = '0;
    if (!bus_write) begin
      for (int k = 0; k < NREG; k++) begin
        if (sel[k]) bus_rdata = bus_rdata | rv[k];
      end
    end
  end

  assign eng_read      = rd_q;
  assign eng_len       = len_q;
  assign cfg_div       = div_q;
  assign cfg_delay     = dly_q;
  assign sda_force_en  = line_q[0];
  assign sda_force_val = line_q[1];
  assign scl_force_en  = line_q[2];
  assign scl_force_val = line_q[3];
  assign init_cfg      = init_q;

  p_read_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_rd |=> (eng_wdata == $past(eng_rdata)));
  p_fail_keeps_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_err && !wr[W_DAT0] && !wr[W_DAT0+1]) |=> $stable(eng_wdata));
endmodule

// File: tb/twc_regfront_tb_top.sv
module twc_regfront_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        bus_valid = 0, bus_write = 0;
  logic [5:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        irq, eng_start, eng_abort, eng_read;
  logic [2:0]  eng_len;
  logic [63:0] eng_index, eng_wdata;
  logic        eng_done = 0, eng_err = 0;
  logic [7:0]  eng_err_id = 0;
  logic [63:0] eng_rdata = 0;
  logic [7:0]  cfg_div;
  logic [2:0]  cfg_delay;
  logic        sda_force_en, sda_force_val, scl_force_en, scl_force_val;
  logic        sda_in = 1, scl_in = 0;
  logic [31:0] init_cfg;

  twc_regfront dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .eng_start(eng_start), .eng_abort(eng_abort), .eng_read(eng_read), .eng_len(eng_len),
    .eng_index(eng_index), .eng_wdata(eng_wdata), .eng_done(eng_done), .eng_err(eng_err),
    .eng_err_id(eng_err_id), .eng_rdata(eng_rdata), .cfg_div(cfg_div), .cfg_delay(cfg_delay),
    .sda_force_en(sda_force_en), .sda_force_val(sda_force_val),
    .scl_force_en(scl_force_en), .scl_force_val(scl_force_val),
    .sda_in(sda_in), .scl_in(scl_in), .init_cfg(init_cfg)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, got, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit          m_busy, m_gie, m_srst, m_go_p, m_stop_p, m_rd;
  bit [2:0]    m_ien, m_st, m_len;
  bit [7:0]    m_eid, m_div;
  bit [2:0]    m_dly;
  bit [3:0]    m_line;
  bit [31:0]   m_idx [2];
  bit [31:0]   m_dat [2];
  bit [31:0]   m_init;
  bit          t_busy, t_rd;

  task automatic m_clear();
    m_busy = 0; m_gie = 0; m_srst = 0; m_go_p = 0; m_stop_p = 0; m_rd = 0;
    m_ien = 0; m_st = 0; m_len = 0; m_eid = 0; m_div = 0; m_dly = 0;
    m_line = 0; m_init = 0;
    foreach (m_idx[k]) begin m_idx[k] = 0; m_dat[k] = 0; end
  endtask

  function automatic bit [31:0] m_read(bit [5:0] a);
    if (a[1:0] != 0) return 0;
    case (a[5:2])
      0:  return (32'(m_busy) << 7) | (32'(m_gie) << 1) | 32'(m_srst);
      1:  return {21'd0, m_dly, m_div};
      2:  return {29'd0, m_ien};
      3:  return {16'd0, m_eid, 5'd0, m_st};
      4:  return m_idx[0];
      5:  return m_idx[1];
      6:  return {27'd0, m_rd, 1'b0, m_len};
      7:  return m_dat[0];
      8:  return m_dat[1];
      9:  return {26'd0, scl_in, sda_in, m_line};
      10: return m_init;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_clear();
    else if (m_srst) begin
      t_busy = m_busy; m_clear(); m_stop_p = t_busy;
    end else begin
      bit wv;
      wv = bus_valid && bus_write && bus_addr[1:0] == 0;
      t_rd = m_rd;
      m_go_p = 0; m_stop_p = 0;
      if (wv && bus_addr[5:2] == 3) m_st = m_st & ~bus_wdata[2:0];
      if (m_busy) begin
        if (wv && bus_addr[5:2] == 0 && bus_wdata[6]) begin
          m_busy = 0; m_stop_p = 1;
        end else begin
          if (wv && bus_addr[5:2] == 0 && bus_wdata[7]) m_st[2] = 1;
          if (eng_done) begin
            m_busy = 0;
            if (eng_err) begin m_st[1] = 1; m_eid = eng_err_id; end
            else m_st[0] = 1;
          end
        end
      end else if (wv && bus_addr[5:2] == 0 && bus_wdata[7]) begin
        m_busy = 1; m_go_p = 1;
      end
      if (wv) begin
        case (bus_addr[5:2])
          0:  begin m_gie = bus_wdata[1]; m_srst = bus_wdata[0]; end
          1:  begin m_div = bus_wdata[7:0]; m_dly = bus_wdata[10:8]; end
          2:  m_ien = bus_wdata[2:0];
          4:  m_idx[0] = bus_wdata;
          5:  m_idx[1] = bus_wdata;
          6:  begin m_len = bus_wdata[2:0]; m_rd = bus_wdata[4]; end
          7:  m_dat[0] = bus_wdata;
          8:  m_dat[1] = bus_wdata;
          9:  m_line = bus_wdata[3:0];
          10: m_init = bus_wdata;
          default: ;
        endcase
      end
      if (eng_done && t_busy_ok() && !eng_err && t_rd) begin
        m_dat[0] = eng_rdata[31:0]; m_dat[1] = eng_rdata[63:32];
      end
    end
  end

  // success completion this edge: model marked done and status bit 0 came from engine
  bit prev_busy;
  always @(posedge clk) prev_busy <= m_busy_before;
  bit m_busy_before;
  always @(negedge clk) m_busy_before = m_busy;
  function automatic bit t_busy_ok();
    return m_busy_before &&
           !(bus_valid && bus_write && bus_addr == 6'h00 && bus_wdata[6]);
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R1 read data", bus_rdata, (bus_valid && !bus_write) ? m_read(bus_addr) : 0);
      chk("R8 irq", irq, m_gie && ((m_st & m_ien) != 0));
      chk("R2 start pulse", eng_start, m_go_p);
      chk("R5 abort pulse", eng_abort, m_stop_p);
      chk("R12 engine setup", {eng_read, eng_len}, {m_rd, m_len});
      chk("R12 index", eng_index, {m_idx[1], m_idx[0]});
      chk("R12 wdata", eng_wdata, {m_dat[1], m_dat[0]});
      chk("R9 clock cfg", {cfg_delay, cfg_div}, {m_dly, m_div});
      chk("R10 line outs", {scl_force_val, scl_force_en, sda_force_val, sda_force_en}, m_line);
      chk("R1 init word", init_cfg, m_init);
    end
  end

  // ---------------- stimulus ----------------
  task automatic bus_wr(bit [5:0] a, bit [31:0] d);
    @(negedge clk); #1;
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1;
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic bus_rd(bit [5:0] a, bit [31:0] exp, string req);
    @(negedge clk); #1;
    bus_valid = 1; bus_write = 0; bus_addr = a;
    #2 chk(req, bus_rdata, exp);
    @(negedge clk); #1;
    bus_valid = 0;
  endtask

  task automatic eng_fin(bit e, bit [7:0] id, bit [63:0] rd);
    @(negedge clk); #1;
    eng_done = 1; eng_err = e; eng_err_id = id; eng_rdata = rd;
    @(negedge clk); #1;
    eng_done = 0; eng_err = 0;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000 && !finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<100000", wd);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 11; a++)
      bus_rd(6'(a * 4), (a == 9) ? 32'h10 : 32'h0, "R1 reset value");
    bus_wr(6'h10, 32'h11223344); bus_wr(6'h14, 32'h55667788);
    bus_rd(6'h14, 32'h55667788, "R1 index readback");
    bus_wr(6'h2C, 32'hFFFFFFFF);
    bus_rd(6'h2C, 0, "R1 unmapped");
    bus_rd(6'h05, 0, "R1 misaligned");
    bus_wr(6'h28, 32'hDEADBEEF);
    bus_rd(6'h28, 32'hDEADBEEF, "R1 init readback");
    // R9 clock config
    bus_wr(6'h04, 32'hFFFFFFFF);
    bus_rd(6'h04, 32'h7FF, "R9 clock readback");
    chk("R9 divider", cfg_div, 8'hFF); chk("R9 delay", cfg_delay, 3'd7);
    // R12 length
    bus_wr(6'h18, 32'hFFFFFFFF);
    bus_rd(6'h18, 32'h17, "R12 length readback");
    chk("R12 eng_len", eng_len, 3'd7); chk("R12 eng_read", eng_read, 1'b1);
    chk("R12 eng_index", eng_index, 64'h55667788_11223344);
    // R2 start
    bus_wr(6'h08, 32'h7);
    bus_wr(6'h00, 32'h82);
    chk("R2 start pulse high", eng_start, 1'b1);
    bus_rd(6'h00, 32'h82, "R2 busy readback");
    chk("R2 start pulse gone", eng_start, 1'b0);
    // R6 start while busy
    bus_wr(6'h00, 32'h82);
    chk("R6 no second start", eng_start, 1'b0);
    bus_rd(6'h0C, 32'h4, "R6 load-busy flag");
    chk("R8 irq raised", irq, 1'b1);
    // R7 clear
    bus_wr(6'h0C, 32'h4);
    bus_rd(6'h0C, 32'h0, "R7 cleared");
    chk("R8 irq dropped", irq, 1'b0);
    // R3/R4 successful read
    eng_fin(0, 0, 64'hAABBCCDD_01020304);
    bus_rd(6'h1C, 32'h01020304, "R4 data word 0");
    bus_rd(6'h20, 32'hAABBCCDD, "R4 data word 1");
    bus_rd(6'h0C, 32'h1, "R3 complete flag");
    bus_rd(6'h00, 32'h02, "R3 busy cleared");
    // R3 error on write transfer
    bus_wr(6'h0C, 32'h1);
    bus_wr(6'h18, 32'h0);
    bus_wr(6'h00, 32'h82);
    eng_fin(1, 8'h5A, 64'h1);
    bus_rd(6'h0C, 32'h5A02, "R3 error and id");
    bus_rd(6'h1C, 32'h01020304, "R4 data kept on error");
    bus_wr(6'h0C, 32'h2);
    bus_rd(6'h0C, 32'h5A00, "R7 id survives clear");
    // R7 set wins over clear
    bus_wr(6'h00, 32'h82);
    @(negedge clk); #1;
    eng_done = 1; bus_valid = 1; bus_write = 1; bus_addr = 6'h0C; bus_wdata = 32'h1;
    @(negedge clk); #1;
    eng_done = 0; bus_valid = 0; bus_write = 0;
    bus_rd(6'h0C, 32'h5A01, "R7 set beats clear");
    bus_wr(6'h0C, 32'h7);
    // R5 abort
    bus_wr(6'h00, 32'h82);
    bus_wr(6'h00, 32'h42);
    chk("R5 abort pulse", eng_abort, 1'b1);
    bus_rd(6'h00, 32'h02, "R5 idle after abort");
    eng_fin(0, 0, 64'h0);
    bus_rd(6'h0C, 32'h5A00, "R5 late done ignored");
    // R8 gating
    bus_wr(6'h00, 32'h82);
    bus_wr(6'h00, 32'h82);
    eng_fin(0, 0, 64'h0);
    chk("R8 irq with status", irq, 1'b1);
    bus_wr(6'h00, 32'h00);
    chk("R8 global gate off", irq, 1'b0);
    bus_wr(6'h08, 32'h2); bus_wr(6'h00, 32'h02);
    chk("R8 masked by enable", irq, 1'b0);
    bus_wr(6'h08, 32'h4);
    chk("R8 enabled source", irq, 1'b1);
    // R10 line control
    sda_in = 0; scl_in = 1;
    bus_wr(6'h24, 32'hFFFFFFFF);
    bus_rd(6'h24, 32'h2F, "R10 line readback");
    chk("R10 overrides", {scl_force_val, scl_force_en, sda_force_val, sda_force_en}, 4'hF);
    // R11 soft reset mid-transfer
    bus_wr(6'h00, 32'h82);
    bus_wr(6'h00, 32'h03);
    bus_valid = 1; bus_write = 0; bus_addr = 6'h00;
    #1 chk("R11 reset bit visible", bus_rdata, 32'h83);
    @(negedge clk); #1;
    bus_valid = 0;
    chk("R11 abort on reset", eng_abort, 1'b1);
    bus_rd(6'h04, 0, "R11 clock cleared");
    bus_rd(6'h24, 32'h20, "R11 line cleared");
    bus_rd(6'h0C, 0, "R11 status cleared");
    bus_rd(6'h00, 0, "R11 control cleared");
    bus_rd(6'h28, 0, "R11 init cleared");
    chk("R11 irq low", irq, 1'b0);
    repeat (3) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule